// File: doc/BRIEF.md
# Dual-Edge Fractional Clock Divider

This block derives a slower clock from a fast input clock. Two programmable unsigned values set the rate: a numerator `fract` and a denominator `divide`. The output frequency is the input frequency times `fract/divide`. The block takes one step on every input half-period, so both input edges can be output edges. Every output transition therefore lands exactly on a rising or a falling edge of the input clock.

At each step an accumulator adds `fract`. When the sum reaches `divide`, `divide` is subtracted and the output toggles. The decisions for both half-periods of an input cycle are made in the rising-edge domain. A rising-edge flop and a falling-edge flop then build the output, so it has no glitches.

A numerator larger than the denominator is not a valid setting. The block then holds the output low and raises an error flag. A zero numerator, a zero denominator or a low enable stops the output quietly.

Top module: `fdiv_dual_edge`

## Requirements
- R1: Over a long run of N input half-periods, the number of output transitions T satisfies |T·divide − N·fract| ≤ 2·divide.
- R2: `clk_out` changes only at a rising or falling edge of `clk_in` and is stable between edges.
- R3: With `fract` equal to `divide`, `clk_out` toggles on every input half-period (divide by one).
- R4: When `divide/fract` is an integer k, every high time and every low time of `clk_out` (after the first) is exactly k input half-periods.
- R5: When `divide/fract` is a half-integer, each high time plus the following low time, and each low time plus the following high time, equals 2·divide/fract input half-periods.
- R6: For any legal ratio, every high time and every low time (after the first) lies between floor(divide/fract) and ceil(divide/fract) input half-periods. The duty cycle is therefore never worse than 2:1, and the jitter is at most half an input period.
- R7: If `fract > divide`, `cfg_err` is 1 after the next rising edge and `clk_out` is low from the following falling edge. `cfg_err` returns to 0 after the first rising edge with a legal setting. It stays 0 for every legal setting.
- R8: `fract` = 0, `divide` = 0 or `en` = 0 drives `clk_out` low within one input period. `cfg_err` stays 0 unless R7 applies.
- R9: Reset is synchronous and active low, sampled on the rising edge. While it is asserted, `clk_out` is low and `cfg_err` is 0, whatever the other inputs are.
- R10: A change of `fract` or `divide` while running restarts the accumulator from zero at the next rising edge. From then on, the output obeys the bounds of the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the output low |
| fract | input | W | Numerator of the frequency ratio |
| divide | input | W | Denominator of the frequency ratio |
| clk_out | output | 1 | Divided clock |
| cfg_err | output | 1 | 1 while the setting has `fract > divide` |

## Verification
The bench builds the block with the default width W = 8. This allows numerators and denominators up to 255, including the zero-denominator corner with a non-zero numerator.

The ratios in the table cover:
- divide by one;
- integer ratios up to seven;
- half-integer ratios;
- the 2:1 worst case duty cycle;
- coarse ratios above seven.

Each run is long enough to give dozens of complete high and low times. Directed cases then change the setting mid-run from a large to a small denominator. This exposes any stale accumulator state.

// File: rtl/fdiv_pkg.sv
// Shared types for the dual-edge fractional divider.
// Assumes: nothing beyond IEEE 1800-2017.
package fdiv_pkg;
    // Classification of the programmed setting.
    typedef enum logic [1:0] {
        CFG_RUN  = 2'd0,
        CFG_IDLE = 2'd1,
        CFG_BAD  = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/fdiv_cfg_check.sv
// Classifies the current enable and ratio inputs.
// BAD when the numerator exceeds the denominator (checked regardless of enable).
// IDLE when disabled or when either value is zero; RUN otherwise.
// Assumes: purely combinational, inputs stable around the rising edge.
module fdiv_cfg_check
    import fdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] fract,
    input  logic [W-1:0] divide,
    output cfg_state_e   state
);
    // Decide the setting class; illegal ratio has priority over idle.
    always_comb begin
        if (fract > divide)
            state = CFG_BAD;
        else if (!en || fract == '0 || divide == '0)
            state = CFG_IDLE;
        else
            state = CFG_RUN;
    end
endmodule

// File: rtl/fdiv_step.sv
// One half-period step of the accumulator: adds the numerator and,
// when the sum reaches the denominator, subtracts it and flags a toggle.
// Assumes: acc_in < divide and fract <= divide, so one subtraction suffices.
module fdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] fract,
    input  logic [W-1:0] divide,
    output logic [W-1:0] acc_out,
    output logic         tog
);
    logic [W:0] sum;

    // Widened sum so a carry out of W bits is never lost.
    assign sum = {1'b0, acc_in} + {1'b0, fract};

    // Threshold test and wrap of the accumulator.
    always_comb begin
        tog     = (sum >= {1'b0, divide});
        acc_out = W'(tog ? (sum - {1'b0, divide}) : sum);
    end
endmodule

// File: rtl/fdiv_edge_out.sv
// Assembles the output clock from a rising-edge flop and a falling-edge flop.
// The output is their XOR. Only one flop can change at any input edge, so the
// output has no glitches and every transition sits on an input edge.
// Assumes: tog_f and clr_f come from rising-edge registers, so they are
// stable half a period before the falling edge that samples them.
module fdiv_edge_out (
    input  logic clk_in,
    input  logic rst_n,
    input  logic hold,
    input  logic tog_r,
    input  logic clr_f,
    input  logic tog_f,
    output logic clk_out
);
    logic q_r;
    logic q_f;

    // Rising-edge half: toggles on the first step's decision, clears on hold.
    always_ff @(posedge clk_in) begin
        if (hold)
            q_r <= 1'b0;
        else
            q_r <= q_r ^ tog_r;
    end

    // Falling-edge half: toggles on the registered second-step decision.
    always_ff @(negedge clk_in) begin
        if (clr_f)
            q_f <= 1'b0;
        else
            q_f <= q_f ^ tog_f;
    end

    assign clk_out = q_r ^ q_f;

    // R8: a hold registered one edge ago leaves both halves, hence the output, low.
    a_r8_held_low : assert property (@(posedge clk_in) disable iff (!rst_n)
        clr_f |-> (!q_f && !clk_out));
endmodule

// File: rtl/fdiv_dual_edge.sv
// Dual-edge fractional clock divider, top level.
// Each rising edge computes two chained accumulator steps: the first for the
// half-period starting now, the second for the half-period starting at the
// next falling edge. The second decision is registered for the falling flop.
// Assumes: single input clock with roughly even duty; synchronous active-low
// reset; ratio inputs change only away from the rising edge.
module fdiv_dual_edge
    import fdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_in,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] fract,
    input  logic [W-1:0] divide,
    output logic         clk_out,
    output logic         cfg_err
);
    localparam int NSTEP = 2;

    cfg_state_e             cfg_st;
    logic                   hold_now;
    logic                   hold_q;
    logic                   restart;
    logic [W-1:0]           acc_q;
    logic [W-1:0]           fract_q;
    logic [W-1:0]           divide_q;
    logic [NSTEP:0][W-1:0]  acc_chain;
    logic [NSTEP-1:0]       tog;
    logic                   tog_f_q;

    fdiv_cfg_check #(.W(W)) u_cfg (
        .en     (en),
        .fract  (fract),
        .divide (divide),
        .state  (cfg_st)
    );

    // Output forced low and accumulator cleared on reset or any non-run setting.
    assign hold_now = !rst_n || (cfg_st != CFG_RUN);

    // Start from zero after a hold or whenever the ratio has changed.
    assign restart = hold_q || (fract != fract_q) || (divide != divide_q);
    assign acc_chain[0] = restart ? '0 : acc_q;

    // Chain of per-half-period steps evaluated in the rising-edge domain.
    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        fdiv_step #(.W(W)) u_step (
            .acc_in  (acc_chain[g]),
            .fract   (fract),
            .divide  (divide),
            .acc_out (acc_chain[g+1]),
            .tog     (tog[g])
        );
    end

    // Accumulator, hold state and falling-half decision register.
    always_ff @(posedge clk_in) begin
        if (hold_now) begin
            acc_q   <= '0;
            hold_q  <= 1'b1;
            tog_f_q <= 1'b0;
        end else begin
            acc_q   <= acc_chain[NSTEP];
            hold_q  <= 1'b0;
            tog_f_q <= tog[1];
        end
    end

    // Snapshot of the ratio for change detection.
    always_ff @(posedge clk_in) begin
        fract_q  <= fract;
        divide_q <= divide;
    end

    // Error flag for an illegal ratio, cleared by reset.
    always_ff @(posedge clk_in) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else
            cfg_err <= (cfg_st == CFG_BAD);
    end

    fdiv_edge_out u_out (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .hold    (hold_now),
        .tog_r   (tog[0]),
        .clr_f   (hold_q),
        .tog_f   (tog_f_q),
        .clk_out (clk_out)
    );

    // R7: an illegal ratio is flagged one edge later.
    a_r7_err_flag : assert property (@(posedge clk_in) disable iff (!rst_n)
        (fract > divide) |=> cfg_err);

    // R6: while running, the accumulator stays below the denominator it used.
    a_r6_acc_range : assert property (@(posedge clk_in) disable iff (!rst_n)
        !hold_q |-> (acc_q < divide_q));

    // R3: equal numerator and denominator toggles on both halves.
    a_r3_unity : assert property (@(posedge clk_in) disable iff (!rst_n)
        (!hold_now && fract == divide) |-> (tog[0] && tog[1]));

    // R10: the first step after a ratio change starts from an empty accumulator.
    a_r10_restart : assert property (@(posedge clk_in) disable iff (!rst_n)
        (!hold_now && fract != fract_q) |-> (acc_chain[0] == '0));
endmodule

// File: tb/fdiv_dual_edge_tb.sv
module fdiv_dual_edge_tb;
    localparam int W  = 8;
    localparam int NS = 240;
    localparam int NV = 12;

    // Ratio table: {fract, divide}.
    localparam logic [15:0] VEC [NV] = '{
        {8'd1, 8'd1}, {8'd7, 8'd7}, {8'd1, 8'd2}, {8'd1, 8'd3},
        {8'd1, 8'd7}, {8'd2, 8'd3}, {8'd2, 8'd5}, {8'd4, 8'd5},
        {8'd3, 8'd8}, {8'd5, 8'd16}, {8'd200, 8'd255}, {8'd5, 8'd37}
    };

    logic         clk_in = 1'b0;
    logic         rst_n  = 1'b0;
    logic         en     = 1'b0;
    logic [W-1:0] fract  = '0;
    logic [W-1:0] divide = '0;
    logic         clk_out;
    logic         cfg_err;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    int  unstable;
    logic lv [0:511];
    int   rl [0:511];

    fdiv_dual_edge #(.W(W)) u_dut (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .en      (en),
        .fract   (fract),
        .divide  (divide),
        .clk_out (clk_out),
        .cfg_err (cfg_err)
    );

    always #10 clk_in = ~clk_in;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs mid low phase, well away from the rising edge.
    task automatic drive(input logic r, input logic e, input int f, input int d);
        @(negedge clk_in);
        #5;
        rst_n  = r;
        en     = e;
        fract  = f[W-1:0];
        divide = d[W-1:0];
    endtask

    // Record the output level of each of the next n half-periods.
    task automatic collect(input int n);
        unstable = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk_in or negedge clk_in);
            #2;
            lv[i] = clk_out;
            #5;
            if (clk_out !== lv[i]) unstable++;
        end
    endtask

    function automatic int ones(input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (lv[i] === 1'b1) c++;
        return c;
    endfunction

    task automatic analyze(input int f, input int d, input int n, input string over);
        int nr = 0;
        int cur = 1;
        int bad = 0;
        int pbad = 0;
        int lo;
        int hi;
        int diff;
        string tag;
        for (int i = 1; i < n; i++) begin
            if (lv[i] === lv[i-1]) cur++;
            else begin
                rl[nr] = cur;
                nr++;
                cur = 1;
            end
        end
        lo = d / f;
        hi = (d + f - 1) / f;
        if (over != "")             tag = over;
        else if (f == d)            tag = "R3 unity";
        else if (d % f == 0)        tag = "R4 integer";
        else if ((2 * d) % f == 0)  tag = "R6 half-integer bounds";
        else                        tag = "R6 bounds";
        for (int k = 1; k < nr; k++)
            if (rl[k] < lo || rl[k] > hi) bad++;
        chk(nr >= 3 && bad == 0, tag, bad, 0);
        if (d % f != 0 && (2 * d) % f == 0) begin
            for (int k = 1; k + 1 < nr; k++)
                if (rl[k] + rl[k+1] != (2 * d) / f) pbad++;
            chk(pbad == 0, "R5 period", pbad, 0);
        end
        diff = nr * d - n * f;
        if (diff < 0) diff = -diff;
        chk(diff <= 2 * d, "R1 transition count", nr, (n * f) / d);
        chk(unstable == 0, "R2 stable between edges", unstable, 0);
        chk(cfg_err == 1'b0, "R7 no error on legal ratio", int'(cfg_err), 0);
    endtask

    initial begin
        // R9: reset state, with a running setting applied during reset.
        repeat (4) @(posedge clk_in);
        #2;
        chk(clk_out == 1'b0, "R9 out low in reset", int'(clk_out), 0);
        chk(cfg_err == 1'b0, "R9 err low in reset", int'(cfg_err), 0);
        drive(1'b0, 1'b1, 1, 1);
        repeat (2) @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0, "R9 reset dominates", ones(20), 0);

        // Table walk over ratios.
        for (int v = 0; v < NV; v++) begin
            int f;
            int d;
            f = int'(VEC[v][15:8]);
            d = int'(VEC[v][7:0]);
            drive(1'b1, 1'b0, f, d);
            repeat (2) @(posedge clk_in);
            drive(1'b1, 1'b1, f, d);
            collect(NS);
            analyze(f, d, NS, "");
        end

        // R10: shrink the denominator mid-run.
        drive(1'b1, 1'b0, 1, 7);
        repeat (2) @(posedge clk_in);
        drive(1'b1, 1'b1, 1, 7);
        collect(40);
        drive(1'b1, 1'b1, 1, 2);
        collect(NS);
        analyze(1, 2, NS, "R10 change restarts");

        // R7: illegal ratio.
        drive(1'b1, 1'b1, 9, 5);
        @(posedge clk_in);
        #2;
        chk(cfg_err == 1'b1, "R7 err set", int'(cfg_err), 1);
        @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0, "R7 out held low", ones(20), 0);
        // R7: zero denominator with non-zero numerator is illegal too.
        drive(1'b1, 1'b1, 3, 0);
        repeat (2) @(posedge clk_in);
        #2;
        chk(cfg_err == 1'b1, "R7 zero divide flagged", int'(cfg_err), 1);
        collect(20);
        chk(ones(20) == 0, "R7 zero divide low", ones(20), 0);
        drive(1'b1, 1'b1, 2, 3);
        @(posedge clk_in);
        #2;
        chk(cfg_err == 1'b0, "R7 err clears", int'(cfg_err), 0);
        collect(40);

        // R8: quiet stop conditions.
        drive(1'b1, 1'b1, 0, 5);
        repeat (2) @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0, "R8 zero fract low", ones(20), 0);
        chk(cfg_err == 1'b0, "R8 zero fract no err", int'(cfg_err), 0);
        drive(1'b1, 1'b1, 0, 0);
        repeat (2) @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0 && cfg_err == 1'b0, "R8 both zero", ones(20), 0);
        drive(1'b1, 1'b1, 1, 1);
        collect(20);
        drive(1'b1, 1'b0, 1, 1);
        repeat (2) @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0, "R8 enable low", ones(20), 0);

        // R9: reset in the middle of a run.
        drive(1'b1, 1'b1, 1, 1);
        collect(20);
        drive(1'b0, 1'b1, 1, 1);
        repeat (2) @(posedge clk_in);
        collect(20);
        chk(ones(20) == 0 && cfg_err == 1'b0, "R9 mid-run reset", ones(20), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk_in);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule